// File: doc/BRIEF.md
# Four-way tree pseudo-LRU replacement unit

This unit keeps the replacement state for a 4-way set-associative cache whose set count is a parameter. Each set holds three tree bits that approximate recency order. True LRU would need six bits per set.

A lookup port takes a set index and the four valid bits of that set. It returns the way to fill on a miss.
- If any way is invalid, the lowest-numbered invalid way is returned.
- If all four ways are valid, the tree bits pick the victim.

An update strobe carries a set index and the way just used, whether that use was a hit or a fill. The unit then rewrites that set's tree bits so that they point away from the used way.

Tag comparison, data storage and writeback belong to the surrounding cache.

Top module: `plru4_repl`

## Requirements
- R1: A synchronous active-high reset clears every set's tree to 000. A lookup of any set with all four ways valid then returns way 0.
- R2: If any valid bit is 0, the victim is the lowest-numbered way whose valid bit is 0, whatever the tree bits hold. Valid bit n belongs to way n.
- R3: With all ways valid, the tree bits (written root, left node, right node) select the victim as follows:
  - 00x selects way 0.
  - 01x selects way 1.
  - 1x0 selects way 2.
  - 1x1 selects way 3.
- R4: An update naming way 0 sets the root bit to 1 and the left node to 1, and leaves the right node unchanged.
- R5: An update naming way 1 sets the root bit to 1 and the left node to 0, and leaves the right node unchanged.
- R6: An update naming way 2 sets the root bit to 0 and the right node to 1, and leaves the left node unchanged.
- R7: An update naming way 3 sets the root bit to 0 and the right node to 0, and leaves the left node unchanged.
- R8: An update changes only the set it names. Every other set keeps its tree bits.
- R9: The victim is combinational from the addressed set's stored bits. An update takes effect at the clock edge where the strobe is high, so a lookup in the same cycle still sees the old bits.
- R10: Starting from 000, an update to way 1, then way 2, then way 0 leaves the tree at 10x, then 0x1, then 111. The all-valid victims after these steps are way 2, way 0 and way 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_set | input | IDX_W | Set index for lookup |
| lk_valid | input | 4 | Valid bits of the looked-up set, bit n for way n |
| lk_victim | output | 2 | Way chosen for replacement |
| upd_en | input | 1 | Strobe: a way of upd_set was used |
| upd_set | input | IDX_W | Set index for the update |
| upd_way | input | 2 | Way that was hit or filled |

## Verification
The victim depends only on the current inputs and the stored bits, so it is due in the same cycle a lookup is presented. The bench drives on the falling edge and samples a moment later, before the next rising edge. An update becomes visible one rising edge after its strobe. The bench therefore reads the resulting victim at the following falling edge, and it reads the pre-update victim in the strobe cycle itself to show the old value still holds.

// File: rtl/plru4_repl.sv
module plru4_repl #(
  parameter int SETS  = 16,
  parameter int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_set,
  input  logic [3:0]       lk_valid,
  output logic [1:0]       lk_victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic [1:0]       upd_way
);

  // bit 2 = root, bit 1 = left node (ways 0/1), bit 0 = right node (ways 2/3)
  logic [2:0] tree_q [SETS];
  logic [2:0] cur, upd_old, upd_new;
  logic [1:0] tree_pick, free_pick;
  logic       any_free;

  assign cur       = tree_q[lk_set];
  assign tree_pick = cur[2] ? {1'b1, cur[0]} : {1'b0, cur[1]};
  assign any_free  = ~&lk_valid;

  always_comb begin
    free_pick = 2'd0;
    for (int w = 3; w >= 0; w--)
      if (!lk_valid[w]) free_pick = 2'(w);
  end

  assign lk_victim = any_free ? free_pick : tree_pick;

  assign upd_old = tree_q[upd_set];

  always_comb begin
    case (upd_way)
      2'd0:    upd_new = {1'b1, 1'b1, upd_old[0]};
      2'd1:    upd_new = {1'b1, 1'b0, upd_old[0]};
      2'd2:    upd_new = {1'b0, upd_old[1], 1'b1};
      default: upd_new = {1'b0, upd_old[1], 1'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (upd_en) begin
      tree_q[upd_set] <= upd_new;
    end
  end

endmodule

module plru4_repl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [IDX_W-1:0] lk_set,
  input logic [3:0]       lk_valid,
  input logic [1:0]       lk_victim,
  input logic             upd_en,
  input logic [IDX_W-1:0] upd_set,
  input logic [1:0]       upd_way
);

  logic [3:0] below;
  assign below = (4'b0001 << lk_victim) - 4'b0001;

  // R2
  free_way_chosen_chk: assert property (@(posedge clk) disable iff (rst)
    (~&lk_valid) |-> !lk_valid[lk_victim]);

  // R2
  lowest_free_chk: assert property (@(posedge clk) disable iff (rst)
    (~&lk_valid) |-> ((~lk_valid & below) == 4'b0000));

  // R1
  reset_victim_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && (&lk_valid)) |-> (lk_victim == 2'd0));

  // R4 R5
  left_use_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en) && !$past(rst) && !$past(upd_way[1]) &&
     lk_set == $past(upd_set) && (&lk_valid)) |-> lk_victim[1]);

  // R6 R7
  right_use_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en) && !$past(rst) && $past(upd_way[1]) &&
     lk_set == $past(upd_set) && (&lk_valid)) |-> !lk_victim[1]);

  // R4 R5 R6 R7
  not_just_used_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_en) && !$past(rst) && lk_set == $past(upd_set) && (&lk_valid))
      |-> (lk_victim != $past(upd_way)));

endmodule

bind plru4_repl plru4_repl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .lk_set(lk_set), .lk_valid(lk_valid),
  .lk_victim(lk_victim), .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way)
);

// File: tb/plru4_repl_bench.sv
`timescale 1ns/1ps
module plru4_repl_bench;
  localparam int SETS  = 16;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [IDX_W-1:0] lk_set = '0;
  logic [3:0]       lk_valid = 4'hF;
  logic [1:0]       lk_victim;
  logic             upd_en = 1'b0;
  logic [IDX_W-1:0] upd_set = '0;
  logic [1:0]       upd_way = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  plru4_repl #(.SETS(SETS)) u_plru4_repl (
    .clk(clk), .rst(rst), .lk_set(lk_set), .lk_valid(lk_valid),
    .lk_victim(lk_victim), .upd_en(upd_en), .upd_set(upd_set), .upd_way(upd_way)
  );

  // {set[3:0], way[1:0], expected all-valid victim after update[1:0]}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    {4'd0,  2'd1, 2'd2},  // R10 R5: 10x (B2=0) -> way 2
    {4'd0,  2'd2, 2'd0},  // R10 R6: 0x1 with B1=0 -> way 0
    {4'd0,  2'd0, 2'd3},  // R10 R4: 111 -> way 3
    {4'd1,  2'd3, 2'd0},  // R7: 000 -> way 0
    {4'd1,  2'd0, 2'd2},  // R4: 110 -> way 2
    {4'd1,  2'd2, 2'd1},  // R6: 011 keeps B1 -> way 1
    {4'd1,  2'd1, 2'd3},  // R5: 101 keeps B2 -> way 3
    {4'd1,  2'd3, 2'd0},  // R7: 000 -> way 0
    {4'd2,  2'd2, 2'd0},  // R6: 001 -> way 0
    {4'd2,  2'd0, 2'd3},  // R4: 111 keeps B2 -> way 3
    {4'd2,  2'd3, 2'd1},  // R7: 010 keeps B1 -> way 1
    {4'd15, 2'd1, 2'd2}   // R5 R3: 100 -> way 2
  };

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if (lk_victim !== exp) begin
      errors++;
      $display("FAIL %s victim=%0d expected=%0d", req, lk_victim, exp);
    end
  endtask

  task automatic look(input logic [IDX_W-1:0] s, input logic [3:0] v,
                      input string req, input logic [1:0] exp);
    lk_set = s; lk_valid = v;
    #1 check(req, exp);
  endtask

  task automatic touch(input logic [IDX_W-1:0] s, input logic [1:0] w);
    @(negedge clk);
    upd_en = 1'b1; upd_set = s; upd_way = w;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int s = 0; s < SETS; s++) look(4'(s), 4'hF, "R1", 2'd0);

    for (int i = 0; i < NV; i++) begin
      touch(VEC[i][7:4], VEC[i][3:2]);
      look(VEC[i][7:4], 4'hF, "R3/R4-R7/R10", VEC[i][1:0]);
    end

    // R2: set 0 holds 111, tree alone would give way 3
    look(4'd0, 4'b1110, "R2", 2'd0);
    look(4'd0, 4'b0101, "R2", 2'd1);
    look(4'd0, 4'b1011, "R2", 2'd2);
    look(4'd0, 4'b0111, "R2", 2'd3);
    look(4'd0, 4'b0000, "R2", 2'd0);

    // R8: untouched set still at reset state, set 0 unchanged by set 1/2 traffic
    look(4'd3, 4'hF, "R8", 2'd0);
    look(4'd0, 4'hF, "R8", 2'd3);

    // R9: lookup in strobe cycle sees old bits
    @(negedge clk);
    upd_en = 1'b1; upd_set = 4'd3; upd_way = 2'd0;
    look(4'd3, 4'hF, "R9", 2'd0);
    @(negedge clk);
    upd_en = 1'b0;
    look(4'd3, 4'hF, "R9", 2'd2);

    // R1: reset mid-run clears all sets
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    look(4'd0, 4'hF, "R1", 2'd0);
    look(4'd3, 4'hF, "R1", 2'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule